// File: doc/BRIEF.md
# Redundant Transaction Pair Validator

This block validates a pair of redundant transactions that execute the same code region on two cores, one marked as the primary copy and one as the shadow copy. Each side ends its transaction with an end request. That request may come from the end of the region, from a system call or interrupt, or from write-set overflow, and the two sides need not give the same cause. The first side to arrive spins until its partner arrives. The block then walks the two buffered write sets in lockstep. At each position it compares the stored addresses, and on an address match it compares the stored data. A difference in entry count is caught before any entry is read.

If every position matches, the block commits the primary side and discards the shadow side, which is not re-executed. If anything differs, the block aborts both sides and then issues a restart to both, so that both run the region again from its start. An optional mode also requires the two register-file signatures to be equal before a commit. A side that is not part of a consistent redundant pair is ordinary: its end request is passed straight through as a commit.

Top module: `txn_pair_validator`

## Requirements
- R1: After reset, commit_o, discard_o, abort_o and restart_o are 2'b00, and done_o, err_o and ws_idx_o are 0.
- R2: Pair mode holds only when both cfg_reliable_i bits are 1, cfg_peer0_i equals CORE_B and cfg_peer1_i equals CORE_A. Outside pair mode, an end_req_i bit gives the same commit_o bit one cycle later, with no abort. In that case cfg_original_i and the peer indices have no other effect.
- R3: In pair mode, an end request from one side alone produces no commit, abort or done. The comparison starts on the edge at which both sides have requested, in either order or together.
- R4: If ws_count0_i differs from ws_count1_i when comparison starts, the pair is aborted on that same edge and no entry is compared.
- R5: Entry k of side 0 is compared only with entry k of side 1, with ws_idx_o = k. The address is compared in one cycle and, if it matches, the data is compared in the next. An address mismatch at entry k aborts 2k+1 cycles after the start edge, and a data mismatch aborts 2k+2 cycles after it.
- R6: When all N entries match, commit and done_o appear 2N cycles after the start edge, or on the start edge itself when N is 0. done_o lasts exactly one cycle.
- R7: A mismatch sets abort_o to 2'b11 with done_o for one cycle, and restart_o is 2'b11 on the following cycle. Commit and abort never appear together.
- R8: When regcmp_en_i is 1 and rf_sig0_i differs from rf_sig1_i, a pair that would otherwise commit is aborted instead, in the same cycle. When regcmp_en_i is 0, the signatures have no effect.
- R9: err_o becomes 1 the cycle after an abort and 0 the cycle after a pair commit.
- R10: On a pair commit, if cfg_original_i[0] is 1 then commit_o=2'b01 and discard_o=2'b10; otherwise commit_o=2'b10 and discard_o=2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_reliable_i | input | 2 | Per-side redundant-transaction flag |
| cfg_original_i | input | 2 | Per-side primary-copy flag (bit 0 selects the committer) |
| cfg_peer0_i | input | PW | Partner core index held by side 0 |
| cfg_peer1_i | input | PW | Partner core index held by side 1 |
| regcmp_en_i | input | 1 | Enable register-file signature check |
| end_req_i | input | 2 | Per-side end-point request pulse |
| ws_count0_i | input | CW | Side 0 write-set entry count |
| ws_count1_i | input | CW | Side 1 write-set entry count |
| ws_idx_o | output | IW | Write-set read position shared by both sides |
| ws_addr0_i | input | AW | Side 0 entry address at ws_idx_o |
| ws_data0_i | input | DW | Side 0 entry data at ws_idx_o |
| ws_addr1_i | input | AW | Side 1 entry address at ws_idx_o |
| ws_data1_i | input | DW | Side 1 entry data at ws_idx_o |
| rf_sig0_i | input | RW | Side 0 register-file signature |
| rf_sig1_i | input | RW | Side 1 register-file signature |
| commit_o | output | 2 | Per-side commit pulse |
| discard_o | output | 2 | Per-side discard pulse |
| abort_o | output | 2 | Per-side abort pulse |
| restart_o | output | 2 | Per-side restart pulse, one cycle after abort |
| done_o | output | 1 | Validation finished (commit or abort) |
| err_o | output | 1 | Outcome of the last validation, 1 after a mismatch |

## Verification
A wrong controller state shows at the ports as a shift in the cycle on which done_o arrives. It can also show as a ws_idx_o value that stops matching half the number of cycles since the start edge, which is visible within one cycle. A lost arrival flag shows as a pair that never finishes, while a stale one shows as a validation that starts on a single request. The bench therefore times each outcome to the exact cycle and follows ws_idx_o through every walk, so that a skipped or repeated entry is caught. The registered error flag and the restart pulse are checked one cycle after every outcome, so a missed update of either shows up before the next validation begins.

// File: rtl/tpv_pkg.sv
package tpv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_PEER,
        ST_CMP_ADDR,
        ST_CMP_DATA,
        ST_COMMIT,
        ST_ABORT
    } tpv_state_e;
endpackage

// File: rtl/tpv_pair_cfg.sv
module tpv_pair_cfg #(
    parameter int NCORES = 4,
    parameter int CORE_A = 0,
    parameter int CORE_B = 1,
    localparam int PW = (NCORES > 1) ? $clog2(NCORES) : 1
) (
    input  logic [1:0]    reliable_i,
    input  logic [1:0]    original_i,
    input  logic [PW-1:0] peer0_i,
    input  logic [PW-1:0] peer1_i,
    output logic          pair_mode_o,
    output logic [1:0]    keep_mask_o
);
    // Both sides redundant and pointing at each other.
    assign pair_mode_o = reliable_i[0] && reliable_i[1]
                      && (peer0_i == PW'(CORE_B))
                      && (peer1_i == PW'(CORE_A));
    // Side whose stores survive a successful validation.
    assign keep_mask_o = original_i[0] ? 2'b01 : 2'b10;
endmodule

// File: rtl/tpv_entry_cmp.sv
module tpv_entry_cmp #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int RW = 32,
    parameter int CW = 4
) (
    input  logic [AW-1:0] addr0_i,
    input  logic [AW-1:0] addr1_i,
    input  logic [DW-1:0] data0_i,
    input  logic [DW-1:0] data1_i,
    input  logic [CW-1:0] cnt0_i,
    input  logic [CW-1:0] cnt1_i,
    input  logic [RW-1:0] rf0_i,
    input  logic [RW-1:0] rf1_i,
    input  logic          rf_en_i,
    output logic          addr_eq_o,
    output logic          data_eq_o,
    output logic          cnt_eq_o,
    output logic          cnt_zero_o,
    output logic          rf_bad_o
);
    assign addr_eq_o  = (addr0_i == addr1_i);
    assign data_eq_o  = (data0_i == data1_i);
    assign cnt_eq_o   = (cnt0_i == cnt1_i);
    assign cnt_zero_o = (cnt0_i == '0);
    assign rf_bad_o   = rf_en_i && (rf0_i != rf1_i);
endmodule

// File: rtl/tpv_fsm.sv
module tpv_fsm
    import tpv_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pair_mode_i,
    input  logic [1:0]    keep_mask_i,
    input  logic [1:0]    end_req_i,
    input  logic          addr_eq_i,
    input  logic          data_eq_i,
    input  logic          cnt_eq_i,
    input  logic          cnt_zero_i,
    input  logic          rf_bad_i,
    input  logic [CW-1:0] cnt_i,
    output logic [IW-1:0] idx_o,
    output logic [1:0]    commit_o,
    output logic [1:0]    discard_o,
    output logic [1:0]    abort_o,
    output logic [1:0]    restart_o,
    output logic          done_o,
    output logic          err_o
);
    tpv_state_e st_q, st_n;
    logic [1:0]    arrived_q;
    logic [IW-1:0] idx_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]    plain_q;
    logic [1:0]    restart_q;
    logic          err_q;
    logic          last_entry;
    tpv_state_e    start_st;

    assign last_entry = ((CW'(idx_q) + CW'(1)) == cnt_q);

    // Decision taken on the edge at which both sides have arrived.
    always_comb begin
        if (!cnt_eq_i)       start_st = ST_ABORT;
        else if (cnt_zero_i) start_st = rf_bad_i ? ST_ABORT : ST_COMMIT;
        else                 start_st = ST_CMP_ADDR;
    end

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (pair_mode_i && (|end_req_i))
                    st_n = (&end_req_i) ? start_st : ST_WAIT_PEER;
            end
            ST_WAIT_PEER: begin
                if (&(arrived_q | end_req_i)) st_n = start_st;
            end
            ST_CMP_ADDR: st_n = addr_eq_i ? ST_CMP_DATA : ST_ABORT;
            ST_CMP_DATA: begin
                if (!data_eq_i)      st_n = ST_ABORT;
                else if (last_entry) st_n = rf_bad_i ? ST_ABORT : ST_COMMIT;
                else                 st_n = ST_CMP_ADDR;
            end
            ST_COMMIT: st_n = ST_IDLE;
            ST_ABORT:  st_n = ST_IDLE;
            default:   st_n = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_n;
    end

    // Walk position, arrival record and registered side outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arrived_q <= 2'b00;
            idx_q     <= '0;
            cnt_q     <= '0;
            plain_q   <= 2'b00;
            restart_q <= 2'b00;
            err_q     <= 1'b0;
        end else begin
            plain_q   <= end_req_i & {2{~pair_mode_i}};
            restart_q <= (st_q == ST_ABORT) ? 2'b11 : 2'b00;
            if (st_q == ST_ABORT)  err_q <= 1'b1;
            if (st_q == ST_COMMIT) err_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    arrived_q <= end_req_i;
                    idx_q     <= '0;
                    cnt_q     <= cnt_i;
                end
                ST_WAIT_PEER: begin
                    arrived_q <= arrived_q | end_req_i;
                    idx_q     <= '0;
                    cnt_q     <= cnt_i;
                end
                ST_CMP_DATA: begin
                    arrived_q <= 2'b00;
                    if (data_eq_i && !last_entry) idx_q <= idx_q + IW'(1);
                end
                default: arrived_q <= 2'b00;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        commit_o  = plain_q;
        discard_o = 2'b00;
        abort_o   = 2'b00;
        done_o    = 1'b0;
        unique case (st_q)
            ST_COMMIT: begin
                commit_o  = plain_q | keep_mask_i;
                discard_o = ~keep_mask_i;
                done_o    = 1'b1;
            end
            ST_ABORT: begin
                abort_o = 2'b11;
                done_o  = 1'b1;
            end
            default: ;
        endcase
    end

    assign idx_o     = idx_q;
    assign restart_o = restart_q;
    assign err_o     = err_q;
endmodule

// File: rtl/txn_pair_validator.sv
module txn_pair_validator #(
    parameter int NCORES = 4,
    parameter int CORE_A = 0,
    parameter int CORE_B = 1,
    parameter int DEPTH  = 8,
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int RW     = 32,
    localparam int PW = (NCORES > 1) ? $clog2(NCORES) : 1,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_reliable_i,
    input  logic [1:0]    cfg_original_i,
    input  logic [PW-1:0] cfg_peer0_i,
    input  logic [PW-1:0] cfg_peer1_i,
    input  logic          regcmp_en_i,
    input  logic [1:0]    end_req_i,
    input  logic [CW-1:0] ws_count0_i,
    input  logic [CW-1:0] ws_count1_i,
    output logic [IW-1:0] ws_idx_o,
    input  logic [AW-1:0] ws_addr0_i,
    input  logic [DW-1:0] ws_data0_i,
    input  logic [AW-1:0] ws_addr1_i,
    input  logic [DW-1:0] ws_data1_i,
    input  logic [RW-1:0] rf_sig0_i,
    input  logic [RW-1:0] rf_sig1_i,
    output logic [1:0]    commit_o,
    output logic [1:0]    discard_o,
    output logic [1:0]    abort_o,
    output logic [1:0]    restart_o,
    output logic          done_o,
    output logic          err_o
);
    logic       pair_mode;
    logic [1:0] keep_mask;
    logic       addr_eq, data_eq, cnt_eq, cnt_zero, rf_bad;

    tpv_pair_cfg #(.NCORES(NCORES), .CORE_A(CORE_A), .CORE_B(CORE_B)) i_cfg (
        .reliable_i (cfg_reliable_i),
        .original_i (cfg_original_i),
        .peer0_i    (cfg_peer0_i),
        .peer1_i    (cfg_peer1_i),
        .pair_mode_o(pair_mode),
        .keep_mask_o(keep_mask)
    );

    tpv_entry_cmp #(.AW(AW), .DW(DW), .RW(RW), .CW(CW)) i_cmp (
        .addr0_i   (ws_addr0_i),
        .addr1_i   (ws_addr1_i),
        .data0_i   (ws_data0_i),
        .data1_i   (ws_data1_i),
        .cnt0_i    (ws_count0_i),
        .cnt1_i    (ws_count1_i),
        .rf0_i     (rf_sig0_i),
        .rf1_i     (rf_sig1_i),
        .rf_en_i   (regcmp_en_i),
        .addr_eq_o (addr_eq),
        .data_eq_o (data_eq),
        .cnt_eq_o  (cnt_eq),
        .cnt_zero_o(cnt_zero),
        .rf_bad_o  (rf_bad)
    );

    tpv_fsm #(.DEPTH(DEPTH)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pair_mode_i(pair_mode),
        .keep_mask_i(keep_mask),
        .end_req_i  (end_req_i),
        .addr_eq_i  (addr_eq),
        .data_eq_i  (data_eq),
        .cnt_eq_i   (cnt_eq),
        .cnt_zero_i (cnt_zero),
        .rf_bad_i   (rf_bad),
        .cnt_i      (ws_count0_i),
        .idx_o      (ws_idx_o),
        .commit_o   (commit_o),
        .discard_o  (discard_o),
        .abort_o    (abort_o),
        .restart_o  (restart_o),
        .done_o     (done_o),
        .err_o      (err_o)
    );
endmodule

// File: rtl/tpv_checker.sv
module tpv_checker #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] ws_count0_i,
    input logic [CW-1:0] ws_count1_i,
    input logic [1:0]    commit_o,
    input logic [1:0]    discard_o,
    input logic [1:0]    abort_o,
    input logic [1:0]    restart_o,
    input logic          done_o,
    input logic          err_o
);
    assert_restart_after_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o == 2'b11) |=> (restart_o == 2'b11));

    assert_no_commit_with_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !((|commit_o) && (|abort_o)));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_discard_opposite_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|discard_o) |-> (($countones(discard_o) == 1) && (commit_o == ~discard_o)));

    assert_err_follows_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(abort_o == 2'b11));

    assert_commit_needs_equal_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|discard_o) |-> (ws_count0_i == ws_count1_i));
endmodule

bind txn_pair_validator tpv_checker #(.CW(CW)) i_tpv_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ws_count0_i(ws_count0_i),
    .ws_count1_i(ws_count1_i),
    .commit_o   (commit_o),
    .discard_o  (discard_o),
    .abort_o    (abort_o),
    .restart_o  (restart_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/test_txn_pair_validator.sv
`timescale 1ns/1ps
module test_txn_pair_validator;
    localparam int PW = 2;
    localparam int CW = 4;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0]    cfg_reliable, cfg_original, end_req;
    logic [PW-1:0] cfg_peer0, cfg_peer1;
    logic          regcmp_en;
    logic [CW-1:0] cnt0, cnt1;
    logic [IW-1:0] ws_idx;
    logic [31:0]   rf0, rf1;
    logic [31:0]   wa0 [0:7];
    logic [31:0]   wd0 [0:7];
    logic [31:0]   wa1 [0:7];
    logic [31:0]   wd1 [0:7];
    logic [1:0]    commit, discard, abort_s, restart;
    logic          done, err;

    int vectors = 0;
    int miscompares = 0;

    txn_pair_validator i_txn_pair_validator (
        .clk(clk), .rst_n(rst_n),
        .cfg_reliable_i(cfg_reliable), .cfg_original_i(cfg_original),
        .cfg_peer0_i(cfg_peer0), .cfg_peer1_i(cfg_peer1),
        .regcmp_en_i(regcmp_en), .end_req_i(end_req),
        .ws_count0_i(cnt0), .ws_count1_i(cnt1), .ws_idx_o(ws_idx),
        .ws_addr0_i(wa0[ws_idx]), .ws_data0_i(wd0[ws_idx]),
        .ws_addr1_i(wa1[ws_idx]), .ws_data1_i(wd1[ws_idx]),
        .rf_sig0_i(rf0), .rf_sig1_i(rf1),
        .commit_o(commit), .discard_o(discard), .abort_o(abort_s),
        .restart_o(restart), .done_o(done), .err_o(err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill(input int n0, input int n1);
        for (int i = 0; i < 8; i++) begin
            wa0[i] = 32'h1000 + 32'(i) * 4; wa1[i] = wa0[i];
            wd0[i] = 32'hA500 + 32'(i) * 7; wd1[i] = wd0[i];
        end
        cnt0 = CW'(n0); cnt1 = CW'(n1);
    endtask

    task automatic pair_cfg(input logic [1:0] orig);
        cfg_reliable = 2'b11; cfg_original = orig;
        cfg_peer0 = 2'd1; cfg_peer1 = 2'd0;
    endtask

    task automatic pulse(input logic [1:0] req);
        @(negedge clk); end_req = req;
        @(negedge clk); end_req = 2'b00;
    endtask

    // Called at the negedge right after the start edge.
    task automatic expect_outcome(input string tag, input int exp_m, input logic [1:0] exp_c,
                                  input logic [1:0] exp_d, input logic [1:0] exp_a);
        int m = 0;
        logic walk_ok = 1'b1;
        while (!done && m < 60) begin
            if (ws_idx !== IW'(m / 2)) walk_ok = 1'b0;
            @(negedge clk); m++;
        end
        check({tag, " R5 walk position"}, 64'(walk_ok), 64'd1);
        check({tag, " R6 done cycle"}, 64'(m), 64'(exp_m));
        check({tag, " R10 commit"}, 64'(commit), 64'(exp_c));
        check({tag, " R10 discard"}, 64'(discard), 64'(exp_d));
        check({tag, " R7 abort"}, 64'(abort_s), 64'(exp_a));
        @(negedge clk);
        check({tag, " R7 restart"}, 64'(restart), (exp_a != 0) ? 64'd3 : 64'd0);
        check({tag, " R9 err flag"}, 64'(err), (exp_a != 0) ? 64'd1 : 64'd0);
        check({tag, " R6 done single"}, 64'(done), 64'd0);
    endtask

    task automatic t_reset();
        check("R1 commit", 64'(commit), 0);
        check("R1 abort", 64'(abort_s), 0);
        check("R1 restart", 64'(restart), 0);
        check("R1 discard", 64'(discard), 0);
        check("R1 done/err", 64'({done, err}), 0);
        check("R1 index", 64'(ws_idx), 0);
    endtask

    task automatic t_plain();
        cfg_reliable = 2'b10; cfg_original = 2'b11; cfg_peer0 = 2'd3; cfg_peer1 = 2'd2;
        fill(3, 1);
        pulse(2'b01);
        check("R2 lone plain commit", 64'(commit), 64'd1);
        check("R2 no abort", 64'(abort_s), 0);
        check("R2 no done", 64'(done), 0);
        @(negedge clk);
        check("R2 commit single", 64'(commit), 0);
        cfg_reliable = 2'b11; cfg_peer0 = 2'd3; cfg_peer1 = 2'd0;
        pulse(2'b11);
        check("R2 bad peer plain commit", 64'(commit), 64'd3);
        check("R2 bad peer no discard", 64'(discard), 0);
        @(negedge clk);
    endtask

    task automatic t_match();
        pair_cfg(2'b01); fill(3, 3);
        pulse(2'b11);
        expect_outcome("match3", 6, 2'b01, 2'b10, 2'b00);
    endtask

    task automatic t_orig1();
        pair_cfg(2'b10); fill(2, 2);
        pulse(2'b11);
        expect_outcome("orig1", 4, 2'b10, 2'b01, 2'b00);
    endtask

    task automatic t_empty();
        pair_cfg(2'b01); fill(0, 0);
        pulse(2'b11);
        expect_outcome("empty R6", 0, 2'b01, 2'b10, 2'b00);
    endtask

    task automatic t_count_mis();
        pair_cfg(2'b01); fill(3, 2);
        pulse(2'b11);
        expect_outcome("count R4", 0, 2'b00, 2'b00, 2'b11);
    endtask

    task automatic t_addr_mis();
        pair_cfg(2'b01); fill(4, 4);
        wa1[1] = wa1[1] ^ 32'h10;
        pulse(2'b11);
        expect_outcome("addr R5", 3, 2'b00, 2'b00, 2'b11);
    endtask

    task automatic t_data_mis();
        pair_cfg(2'b01); fill(4, 4);
        wd1[2] = wd1[2] ^ 32'h1;
        pulse(2'b11);
        expect_outcome("data R5", 6, 2'b00, 2'b00, 2'b11);
    endtask

    task automatic t_spin();
        logic quiet = 1'b1;
        pair_cfg(2'b01); fill(2, 2);
        pulse(2'b10);
        for (int i = 0; i < 6; i++) begin
            if (done || (commit != 0) || (abort_s != 0)) quiet = 1'b0;
            @(negedge clk);
        end
        check("R3 lone request spins", 64'(quiet), 64'd1);
        pulse(2'b01);
        expect_outcome("spin R3", 4, 2'b01, 2'b10, 2'b00);
    endtask

    task automatic t_regcmp();
        pair_cfg(2'b01); fill(2, 2);
        rf0 = 32'h1234; rf1 = 32'h1235; regcmp_en = 1'b1;
        pulse(2'b11);
        expect_outcome("regcmp on R8", 4, 2'b00, 2'b00, 2'b11);
        regcmp_en = 1'b0;
        pulse(2'b11);
        expect_outcome("regcmp off R8", 4, 2'b01, 2'b10, 2'b00);
        regcmp_en = 1'b1; fill(0, 0);
        pulse(2'b11);
        expect_outcome("regcmp empty R8", 0, 2'b00, 2'b00, 2'b11);
        regcmp_en = 1'b0; rf1 = rf0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        cfg_reliable = 2'b00; cfg_original = 2'b00; cfg_peer0 = '0; cfg_peer1 = '0;
        regcmp_en = 1'b0; end_req = 2'b00; rf0 = 32'h55; rf1 = 32'h55;
        fill(0, 0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_match();
        t_orig1();
        t_empty();
        t_count_mis();
        t_match();
        t_addr_mis();
        t_data_mis();
        t_spin();
        t_regcmp();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule